// File: doc/BRIEF.md
# DMA cache-line request splitter

This block takes one DMA transfer at a time from a requester and turns it into a series of memory sub-requests. The requester gives a start byte address, a byte length, a direction and, for writes, the data. Each sub-request covers at most one cache line. The first sub-request runs from the start offset to the end of its line, or to the end of the transfer if that comes first. Every later sub-request starts on a line boundary. Only one sub-request is in flight at a time. The next one is presented only after the memory side acknowledges a store or returns the read beat for a load.

When the last sub-request is acknowledged, the block frees itself. One cycle later it gives the requester a single response, which carries the gathered read bytes for a load. A request that arrives while a transfer is active is refused. That refusal is remembered, and a retry pulse goes out once the block is free again. A drain handshake reports at once whether anything is outstanding. If something is, it signals drain-done when that transfer ends.

Top module: `dma_line_splitter`

## Requirements
- R1: `req_ready` is high exactly when no transfer is active, and a handshake (`req_valid` and `req_ready`) captures address, length (1 to MAX_BYTES), direction, response flag and write data.
- R2: While a transfer is active, `req_valid` raises `req_refused` in the same cycle with `req_ready` low, and the refused request has no effect on the active transfer's sub-requests.
- R3: The first sub-request has `mem_offset` equal to the start address modulo LINE_BYTES, `mem_line_addr` equal to the start address divided by LINE_BYTES, and `mem_len` equal to the smaller of the length and LINE_BYTES minus the offset.
- R4: Each later sub-request targets the start address plus the bytes already completed, which is line aligned, so `mem_offset` is 0.
- R5: Each later sub-request has `mem_len` equal to the smaller of the remaining bytes and LINE_BYTES.
- R6: `mem_valid` holds with stable fields until `mem_ready`. After that handshake no sub-request is presented until the completion event arrives: `mem_ack` for stores (`mem_store` = 1) or `mem_rvalid` for loads (`mem_store` = 0).
- R7: For a store, byte lane b of `mem_wdata` (bits 8b+7..8b) carries request byte `done + b - mem_offset` for lanes `mem_offset` up to `mem_offset + mem_len - 1`. Request byte k sits in bits 8k+7..8k of `req_wdata`. `mem_wbe` has exactly those lanes set, and every other lane is zero.
- R8: For a load, response byte i of `rsp_rdata` equals the memory byte at start address + i for every i below the length. Bytes at or above the length read zero.
- R9: If the response flag was set, `rsp_valid` pulses for exactly one cycle, one cycle after the final completion event. In that same cycle `rsp_write` echoes the direction and `req_ready` is already high. If the flag was clear, no response is given.
- R10: If any request was refused during a transfer, `retry_pulse` is high for one cycle together with the response cycle. Otherwise it stays low.
- R11: `drain_req` while idle raises `drain_now` in the same cycle. `drain_req` during a transfer keeps `drain_now` low, and `drain_done` then pulses in the cycle after that transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester offers a transfer |
| req_ready | output | 1 | Block is idle and accepts a transfer |
| req_write | input | 1 | 1 = store transfer, 0 = load transfer |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_want_rsp | input | 1 | A response is wanted on completion |
| req_wdata | input | MAX_BYTES*8 | Store data, byte k in bits 8k+7..8k |
| req_refused | output | 1 | Offered transfer is refused because the block is busy |
| retry_pulse | output | 1 | A previously refused requester may try again |
| mem_valid | output | 1 | Sub-request presented |
| mem_ready | input | 1 | Memory side takes the sub-request |
| mem_store | output | 1 | Sub-request type: 1 = store, 0 = load |
| mem_line_addr | output | ADDR_W-OFF_W | Line address of the sub-request |
| mem_offset | output | OFF_W | Byte offset within the line |
| mem_len | output | LEN_W | Bytes covered by the sub-request |
| mem_wdata | output | LINE_BYTES*8 | Store data placed at the line lanes |
| mem_wbe | output | LINE_BYTES | Byte enables of the store lanes |
| mem_ack | input | 1 | Store sub-request completed |
| mem_rvalid | input | 1 | Load sub-request data beat valid |
| mem_rdata | input | LINE_BYTES*8 | Full line of load data |
| rsp_valid | output | 1 | Transfer response pulse |
| rsp_write | output | 1 | Direction of the completed transfer |
| rsp_rdata | output | MAX_BYTES*8 | Gathered load bytes, byte i in bits 8i+7..8i |
| drain_req | input | 1 | Drain query |
| drain_now | output | 1 | Nothing outstanding, drained at once |
| drain_done | output | 1 | Outstanding transfer finished after a drain query |

## Verification
The bench sweeps every start offset within a line against every length from one byte to the maximum, for both loads and stores, with the line set to 8 bytes. This drives transfers that fit in one line, that end exactly on a boundary, and that span several lines with a partial head and tail. A design that clipped the first sub-request wrongly would overrun into the next line or leave a gap. One that kept the start offset on later lines would misplace store lanes or gather load bytes from the wrong lanes. A wrong remaining-byte count would shift the tail, and the bench catches that through the per-sub-request fields and the gathered response bytes. Refusals, drain queries during a transfer and memory-side stalls are mixed into the sweep. These show whether a design frees itself late, so that the retry or drain pulse lands in the wrong cycle, or whether it issues a second sub-request before the first completes.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LEN_W      = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  done_bytes,
    input  logic [LEN_W-1:0]  total_bytes,
    output logic [LA_W-1:0]   line_addr,
    output logic [OFF_W-1:0]  offset,
    output logic [LEN_W-1:0]  chunk_len
);
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  room;

    always_comb begin
        cur_addr  = start_addr + ADDR_W'(done_bytes);
        line_addr = cur_addr[ADDR_W-1:OFF_W];
        offset    = cur_addr[OFF_W-1:0];
        remain    = total_bytes - done_bytes;
        room      = LEN_W'(LINE_BYTES) - LEN_W'(offset);
        chunk_len = (remain < room) ? remain : room;
    end
endmodule

// File: rtl/dma_wr_place.sv
module dma_wr_place #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    parameter int LEN_W      = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic [MAX_BYTES*8-1:0]  wbuf,
    input  logic [LEN_W-1:0]        done_bytes,
    input  logic [OFF_W-1:0]        offset,
    input  logic [LEN_W-1:0]        chunk_len,
    output logic [LINE_BYTES*8-1:0] wdata,
    output logic [LINE_BYTES-1:0]   wbe
);
    logic [7:0] wbytes [MAX_BYTES];

    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_unpack
        assign wbytes[k] = wbuf[k*8 +: 8];
    end

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic [LEN_W:0] lo;
        logic [LEN_W:0] hi;
        logic [LEN_W:0] src;
        logic           hit;
        always_comb begin
            lo  = (LEN_W+1)'(offset);
            hi  = lo + (LEN_W+1)'(chunk_len);
            src = (LEN_W+1)'(done_bytes) + (LEN_W+1)'(b) - lo;
            hit = ((LEN_W+1)'(b) >= lo) && ((LEN_W+1)'(b) < hi)
                  && (src < (LEN_W+1)'(MAX_BYTES));
            wbe[b]         = hit;
            wdata[b*8 +: 8] = hit ? wbytes[src[IDX_W-1:0]] : 8'h00;
        end
    end
endmodule

// File: rtl/dma_rd_merge.sv
module dma_rd_merge #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    parameter int LEN_W      = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [MAX_BYTES*8-1:0]  rbuf_q,
    input  logic [LINE_BYTES*8-1:0] rdata,
    input  logic [LEN_W-1:0]        done_bytes,
    input  logic [LEN_W-1:0]        issued_bytes,
    input  logic [OFF_W-1:0]        offset,
    output logic [MAX_BYTES*8-1:0]  rbuf_d
);
    logic [7:0] lanes [LINE_BYTES];

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_unpack
        assign lanes[b] = rdata[b*8 +: 8];
    end

    for (genvar j = 0; j < MAX_BYTES; j++) begin : g_byte
        logic [LEN_W:0] src;
        logic           hit;
        always_comb begin
            src = (LEN_W+1)'(j) - (LEN_W+1)'(done_bytes) + (LEN_W+1)'(offset);
            hit = (LEN_W'(j) >= done_bytes) && (LEN_W'(j) < issued_bytes);
            rbuf_d[j*8 +: 8] = hit ? lanes[src[OFF_W-1:0]] : rbuf_q[j*8 +: 8];
        end
    end
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
    import dma_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int LA_W      = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len,
    input  logic                    req_want_rsp,
    input  logic [MAX_BYTES*8-1:0]  req_wdata,
    output logic                    req_refused,
    output logic                    retry_pulse,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_store,
    output logic [LA_W-1:0]         mem_line_addr,
    output logic [OFF_W-1:0]        mem_offset,
    output logic [LEN_W-1:0]        mem_len,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    output logic [LINE_BYTES-1:0]   mem_wbe,
    input  logic                    mem_ack,
    input  logic                    mem_rvalid,
    input  logic [LINE_BYTES*8-1:0] mem_rdata,
    output logic                    rsp_valid,
    output logic                    rsp_write,
    output logic [MAX_BYTES*8-1:0]  rsp_rdata,
    input  logic                    drain_req,
    output logic                    drain_now,
    output logic                    drain_done
);

    typedef struct packed {
        phase_e                 phase;
        logic                   write;
        logic                   want_rsp;
        logic [ADDR_W-1:0]      start;
        logic [LEN_W-1:0]       total;
        logic [LEN_W-1:0]       done;
        logic [LEN_W-1:0]       issued;
        logic [MAX_BYTES*8-1:0] wbuf;
        logic [MAX_BYTES*8-1:0] rbuf;
        logic                   retry;
        logic                   drain_pend;
        logic                   rsp_valid;
        logic                   retry_pulse;
        logic                   drain_done;
    } state_t;

    state_t st_q, st_d;

    logic                   busy;
    logic                   refused;
    logic                   beat_in;
    logic [LEN_W-1:0]       chunk_len;
    logic [MAX_BYTES*8-1:0] rbuf_merged;

    assign busy    = (st_q.phase != PH_IDLE);
    assign refused = req_valid && busy;
    assign beat_in = st_q.write ? mem_ack : mem_rvalid;

    dma_chunk_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) u_calc (
        .start_addr (st_q.start),
        .done_bytes (st_q.done),
        .total_bytes(st_q.total),
        .line_addr  (mem_line_addr),
        .offset     (mem_offset),
        .chunk_len  (chunk_len)
    );

    dma_wr_place #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_wr (
        .wbuf      (st_q.wbuf),
        .done_bytes(st_q.done),
        .offset    (mem_offset),
        .chunk_len (chunk_len),
        .wdata     (mem_wdata),
        .wbe       (mem_wbe)
    );

    dma_rd_merge #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_rd (
        .rbuf_q      (st_q.rbuf),
        .rdata       (mem_rdata),
        .done_bytes  (st_q.done),
        .issued_bytes(st_q.issued),
        .offset      (mem_offset),
        .rbuf_d      (rbuf_merged)
    );

    always_comb begin
        st_d             = st_q;
        st_d.rsp_valid   = 1'b0;
        st_d.retry_pulse = 1'b0;
        st_d.drain_done  = 1'b0;
        if (refused) st_d.retry = 1'b1;
        if (drain_req && busy) st_d.drain_pend = 1'b1;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase    = PH_SEND;
                    st_d.write    = req_write;
                    st_d.want_rsp = req_want_rsp;
                    st_d.start    = req_addr;
                    st_d.total    = req_len;
                    st_d.done     = '0;
                    st_d.issued   = '0;
                    st_d.wbuf     = req_wdata;
                    st_d.rbuf     = '0;
                end
            end
            PH_SEND: begin
                if (mem_ready) begin
                    st_d.issued = st_q.done + chunk_len;
                    st_d.phase  = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (beat_in) begin
                    st_d.done = st_q.issued;
                    if (!st_q.write) st_d.rbuf = rbuf_merged;
                    if (st_q.issued == st_q.total) begin
                        st_d.phase       = PH_IDLE;
                        st_d.rsp_valid   = st_q.want_rsp;
                        st_d.retry_pulse = st_d.retry;
                        st_d.retry       = 1'b0;
                        st_d.drain_done  = st_d.drain_pend;
                        st_d.drain_pend  = 1'b0;
                    end else begin
                        st_d.phase = PH_SEND;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready   = !busy;
    assign req_refused = refused;
    assign retry_pulse = st_q.retry_pulse;
    assign mem_valid   = (st_q.phase == PH_SEND);
    assign mem_store   = st_q.write;
    assign mem_len     = chunk_len;
    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_write   = st_q.write;
    assign rsp_rdata   = st_q.rbuf;
    assign drain_now   = drain_req && !busy;
    assign drain_done  = st_q.drain_done;

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> (req_len != '0) && (req_len <= LEN_W'(MAX_BYTES))); // R1
    AST_REFUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && busy |=> $stable(st_q.start) && $stable(st_q.total)); // R2
    AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((LEN_W+1)'(mem_offset) + (LEN_W+1)'(mem_len)) <= (LEN_W+1)'(LINE_BYTES)); // R3
    AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && (st_q.done != '0) |-> (mem_offset == '0)); // R4
    AST_CHUNK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_len != '0)); // R5
    AST_HOLD_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_line_addr)
                                    && $stable(mem_offset) && $stable(mem_len)); // R6
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid); // R6
    AST_DONE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> st_q.done >= $past(st_q.done)); // R4
    AST_RSP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(busy) && req_ready); // R9
    AST_RETRY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> $past(busy) && req_ready); // R10
    AST_DRAIN_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> $past(busy) && !busy); // R11

endmodule

// File: tb/tb_dma_line_splitter.sv
module tb_dma_line_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int LINE = 8;
    localparam int MAXB = 32;
    localparam int OFFW = $clog2(LINE);
    localparam int LW   = $clog2(MAXB + 1);
    localparam int LAW  = AW - OFFW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_want_rsp = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [MAXB*8-1:0] req_wdata = '0;
    logic req_ready, req_refused, retry_pulse;
    logic mem_valid, mem_store;
    logic mem_ready = 1'b0, mem_ack = 1'b0, mem_rvalid = 1'b0;
    logic [LAW-1:0] mem_line_addr;
    logic [OFFW-1:0] mem_offset;
    logic [LW-1:0] mem_len;
    logic [LINE*8-1:0] mem_wdata;
    logic [LINE-1:0] mem_wbe;
    logic [LINE*8-1:0] mem_rdata = '0;
    logic rsp_valid, rsp_write;
    logic [MAXB*8-1:0] rsp_rdata;
    logic drain_req = 1'b0;
    logic drain_now, drain_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_line_splitter #(.ADDR_W(AW), .LINE_BYTES(LINE), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_want_rsp(req_want_rsp),
        .req_wdata(req_wdata), .req_refused(req_refused), .retry_pulse(retry_pulse),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_store(mem_store),
        .mem_line_addr(mem_line_addr), .mem_offset(mem_offset), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_wbe(mem_wbe), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata),
        .drain_req(drain_req), .drain_now(drain_now), .drain_done(drain_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [MAXB*8-1:0] act,
                       input logic [MAXB*8-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int a);
        return 8'((a * 7 + 3) ^ (a >> 5));
    endfunction

    task automatic run_req(input bit wr, input int addr, input int len, input bit want,
                           input int seed, input bit do_refuse, input bit do_drain);
        int done = 0;
        int idx = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 idle ready", MAXB*8'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_len = LW'(len);
        req_want_rsp = want;
        for (int k = 0; k < MAXB; k++) req_wdata[k*8 +: 8] = 8'(k * 13 + seed);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 busy after accept", MAXB*8'(req_ready), 0);
        if (do_drain) begin
            drain_req = 1'b1;
            #1;
            chk(drain_now == 1'b0, "R11 drain while busy", MAXB*8'(drain_now), 0);
            @(negedge clk);
            drain_req = 1'b0;
        end
        if (do_refuse) begin
            req_valid = 1'b1; req_addr = AW'(addr + 3); req_len = LW'(1); req_write = ~wr;
            #1;
            chk(req_refused == 1'b1 && req_ready == 1'b0, "R2 refused while busy",
                MAXB*8'({req_refused, req_ready}), 2);
            @(negedge clk);
            req_valid = 1'b0; req_write = wr;
        end
        while (done < len) begin
            int g = 0;
            int cur = addr + done;
            int off = cur % LINE;
            int clen = (len - done < LINE - off) ? len - done : LINE - off;
            logic [LINE*8-1:0] ew = '0;
            logic [LINE-1:0] ebe = '0;
            while (!mem_valid && g < 50) begin @(negedge clk); g++; end
            if (!mem_valid) begin
                chk(1'b0, "R6 sub-request missing", 0, 1);
                return;
            end
            if (done == 0) begin
                chk(mem_line_addr == LAW'(cur / LINE) && mem_offset == OFFW'(off),
                    "R3 first line/offset", MAXB*8'({mem_line_addr, mem_offset}),
                    MAXB*8'({LAW'(cur / LINE), OFFW'(off)}));
                chk(mem_len == LW'(clen), "R3 first length", MAXB*8'(mem_len), MAXB*8'(clen));
            end else begin
                chk(mem_line_addr == LAW'(cur / LINE) && mem_offset == '0,
                    "R4 later line aligned", MAXB*8'({mem_line_addr, mem_offset}),
                    MAXB*8'({LAW'(cur / LINE), OFFW'(0)}));
                chk(mem_len == LW'(clen), "R5 later length", MAXB*8'(mem_len), MAXB*8'(clen));
            end
            chk(mem_store == wr, "R6 type bit", MAXB*8'(mem_store), MAXB*8'(wr));
            if (wr) begin
                for (int b = 0; b < LINE; b++) begin
                    if (b >= off && b < off + clen) begin
                        ew[b*8 +: 8] = 8'((done + b - off) * 13 + seed);
                        ebe[b] = 1'b1;
                    end
                end
                chk(mem_wdata == ew && mem_wbe == ebe, "R7 store lanes",
                    MAXB*8'({mem_wbe, mem_wdata}), MAXB*8'({ebe, ew}));
            end
            if (idx % 2 == 1) begin
                @(negedge clk);
                chk(mem_valid && mem_len == LW'(clen), "R6 hold while stalled",
                    MAXB*8'(mem_len), MAXB*8'(clen));
            end
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
            for (int w = 0; w < 1 + (idx % 3); w++) begin
                chk(mem_valid == 1'b0, "R6 no second sub-request", MAXB*8'(mem_valid), 0);
                @(negedge clk);
            end
            if (wr) mem_ack = 1'b1;
            else begin
                mem_rvalid = 1'b1;
                for (int b = 0; b < LINE; b++) mem_rdata[b*8 +: 8] = mbyte((cur / LINE) * LINE + b);
            end
            chk(rsp_valid == 1'b0, "R9 no early response", MAXB*8'(rsp_valid), 0);
            @(negedge clk);
            mem_ack = 1'b0; mem_rvalid = 1'b0;
            done += clen;
            idx++;
        end
        chk(rsp_valid == want, "R9 response pulse", MAXB*8'(rsp_valid), MAXB*8'(want));
        chk(req_ready == 1'b1, "R9 free at response", MAXB*8'(req_ready), 1);
        if (want) chk(rsp_write == wr, "R9 direction echo", MAXB*8'(rsp_write), MAXB*8'(wr));
        chk(retry_pulse == do_refuse, "R10 retry pulse", MAXB*8'(retry_pulse), MAXB*8'(do_refuse));
        chk(drain_done == do_drain, "R11 drain done", MAXB*8'(drain_done), MAXB*8'(do_drain));
        if (!wr && want) begin
            logic [MAXB*8-1:0] er = '0;
            for (int i = 0; i < len; i++) er[i*8 +: 8] = mbyte(addr + i);
            chk(rsp_rdata == er, "R8 gathered load bytes", rsp_rdata, er);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0 && retry_pulse == 1'b0 && drain_done == 1'b0,
            "R9 R10 single-cycle pulses", MAXB*8'({rsp_valid, retry_pulse, drain_done}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_valid && !rsp_valid && !retry_pulse && !drain_done,
            "R1 reset state", MAXB*8'({req_ready, mem_valid, rsp_valid, retry_pulse, drain_done}),
            MAXB*8'(5'b10000));
        drain_req = 1'b1;
        #1;
        chk(drain_now == 1'b1, "R11 drained at once when idle", MAXB*8'(drain_now), 1);
        @(negedge clk);
        drain_req = 1'b0;
        chk(drain_done == 1'b0, "R11 no done pulse when idle", MAXB*8'(drain_done), 0);
        for (int wr = 0; wr < 2; wr++) begin
            for (int off = 0; off < LINE; off++) begin
                for (int len = 1; len <= MAXB; len++) begin
                    int addr = ((len * 3 + off) % 64) * LINE + off;
                    bit want = (wr == 0) ? 1'b1 : bit'(len % 2);
                    run_req(bit'(wr), addr, len, want, off * 5 + len,
                            bit'(len % 5 == 0), bit'(len % 7 == 3));
                end
            end
        end
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule